// File: doc/BRIEF.md
# Hiccup Fault Supervisor

This block is the digital protection sequencer for a synchronous step-down converter controller. Every clock it receives digitized readings of the bias supply, the programmed input-supply sense node, the die temperature, the feedback node and the soft-start level. Three hysteretic comparators turn the supply and temperature readings into lockout flags. A short-circuit detector checks feedback against whichever reference is active: the soft-start level while it is below the fixed 0.8 V reference, and the fixed reference after that.

Any fault stops switching. The block then holds the gate drivers off and discharges soft-start and compensation for a fixed idle period, counted in clock cycles. When the idle period ends it restarts only if no supply or thermal lockout is present. Otherwise it waits until every lockout clears. A short circuit only triggers the idle period. It is not held, so while a short persists the block retries once per idle period. Each restart is marked by a one-cycle pulse, and the soft-start ramp is expected to start again from zero.

Top module: `hiccup_supervisor`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `drv_off` = 1, `discharge` = 1 and `restart_pulse` = 0. All lockout flags start in their faulted state.
- R2: The bias flag becomes good at a clock edge where `vbias_mv` >= 4250 and becomes bad at an edge where `vbias_mv` < 4050. Between those values it keeps its previous state.
- R3: The input-sense flag becomes good at an edge where `vin_sense_mv` > 2500 (2500 itself does not release it) and becomes bad at an edge where `vin_sense_mv` < 2200. Between those values it keeps its state.
- R4: The thermal flag becomes hot at an edge where `temp_c` >= 145 (signed degrees) and cools at an edge where `temp_c` <= 135. Between those values it keeps its state.
- R5: A short is present when `fb_mv` + 250 < target, where target = `ss_mv` if `ss_mv` < 800 and target = 800 otherwise. While running, a short stops switching at the next clock edge.
- R6: A lockout flag that goes bad while running stops switching one edge after the flag changes. Once stopped, `drv_off` and `discharge` are both 1 for at least IDLE_CYC consecutive cycles.
- R7: If the only fault is a short, running resumes exactly IDLE_CYC cycles after it stopped. While the short persists this repeats with a period of IDLE_CYC+1 cycles.
- R8: `restart_pulse` is 1 for exactly one cycle, in the first cycle in which `drv_off` is 0 after being 1.
- R9: If a lockout flag is still bad when the idle period ends, `drv_off` stays 1 until all lockout flags are good. Running then resumes one edge after the last flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vbias_mv | input | MV_W | Bias supply reading, unsigned millivolts |
| vin_sense_mv | input | MV_W | Input-supply sense reading, unsigned millivolts |
| temp_c | input | T_W | Die temperature, signed degrees Celsius |
| fb_mv | input | MV_W | Feedback reading, unsigned millivolts |
| ss_mv | input | MV_W | Soft-start level, unsigned millivolts |
| drv_off | output | 1 | Both gate drivers held off |
| discharge | output | 1 | Pull soft-start and compensation low |
| restart_pulse | output | 1 | One-cycle marker of a restart |

## Verification
Directed cases place each comparator input just inside and just outside its hysteresis band. This separates an inclusive threshold from an exclusive one, and a held flag from a re-evaluated one. A persistent short is held over three idle periods and the restart pulses are counted. This shows the short is self-clearing while a thermal or supply fault left at the end of idle blocks restart. A short at a low soft-start level shows the detector follows the ramp and not the fixed reference. Random readings clustered around every threshold are then compared cycle by cycle against a reference model in the bench.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_HOLD = 2'd2
  } hic_state_t;

  // Hysteresis step: a rising condition wins, a falling condition clears,
  // otherwise the flag keeps its value.
  function automatic logic hyst_step(input logic prev, input logic rise, input logic fall);
    if (rise) return 1'b1;
    if (fall) return 1'b0;
    return prev;
  endfunction

  // Active reference: soft-start level until it reaches the fixed reference.
  function automatic int pick_target(input int ss, input int vref);
    return (ss < vref) ? ss : vref;
  endfunction

  // True when feedback trails the target by more than the margin.
  function automatic logic trails_target(input int fb, input int target, input int margin);
    return (fb + margin) < target;
  endfunction

endpackage

// File: rtl/hyst_flag.sv
module hyst_flag #(
  parameter int W        = 17,
  parameter int SET_AT   = 0,
  parameter int CLR_AT   = 0,
  parameter bit SET_INCL = 1'b1,
  parameter bit CLR_INCL = 1'b0,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] val,
  output logic                flag
);
  import hiccup_pkg::*;

  int   v;
  logic rise;
  logic fall;

  assign v = int'(val);

  generate
    if (SET_INCL) begin : g_set_ge
      assign rise = (v >= SET_AT);
    end else begin : g_set_gt
      assign rise = (v > SET_AT);
    end
    if (CLR_INCL) begin : g_clr_le
      assign fall = (v <= CLR_AT);
    end else begin : g_clr_lt
      assign fall = (v < CLR_AT);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= RST_VAL;
    else        flag <= hyst_step(flag, rise, fall);
  end
endmodule

// File: rtl/short_detect.sv
module short_detect #(
  parameter int MV_W         = 16,
  parameter int VREF_MV      = 800,
  parameter int SHORT_MARGIN = 250
) (
  input  logic [MV_W-1:0] fb_mv,
  input  logic [MV_W-1:0] ss_mv,
  output logic            short_now
);
  import hiccup_pkg::*;

  int target;

  assign target    = pick_target(int'(ss_mv), VREF_MV);
  assign short_now = trails_target(int'(fb_mv), target, SHORT_MARGIN);
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
  parameter int IDLE_CYC = 130000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_bad,
  input  logic short_now,
  output logic drv_off,
  output logic discharge,
  output logic restart_pulse
);
  import hiccup_pkg::*;

  localparam int CNT_W = (IDLE_CYC > 2) ? $clog2(IDLE_CYC) : 1;

  hic_state_t       state;
  hic_state_t       nxt;
  logic [CNT_W-1:0] cnt;
  logic             idle_last;

  assign idle_last = (state == ST_IDLE) && (cnt == CNT_W'(IDLE_CYC - 1));

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:  if (pwr_bad || short_now) nxt = ST_IDLE;
      ST_IDLE: if (idle_last) nxt = pwr_bad ? ST_HOLD : ST_RUN;
      ST_HOLD: if (!pwr_bad) nxt = ST_RUN;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      cnt           <= '0;
      restart_pulse <= 1'b0;
    end else begin
      state         <= nxt;
      restart_pulse <= (nxt == ST_RUN) && (state != ST_RUN);
      if (state == ST_IDLE && !idle_last) cnt <= cnt + 1'b1;
      else                                cnt <= '0;
    end
  end

  assign drv_off   = (state != ST_RUN);
  assign discharge = (state != ST_RUN);
endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor #(
  parameter int MV_W         = 16,
  parameter int T_W          = 10,
  parameter int IDLE_CYC     = 130000,
  parameter int BIAS_ON      = 4250,
  parameter int BIAS_OFF     = 4050,
  parameter int VIN_ON       = 2500,
  parameter int VIN_OFF      = 2200,
  parameter int HOT_ON       = 145,
  parameter int HOT_OFF      = 135,
  parameter int VREF_MV      = 800,
  parameter int SHORT_MARGIN = 250
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MV_W-1:0]       vbias_mv,
  input  logic [MV_W-1:0]       vin_sense_mv,
  input  logic signed [T_W-1:0] temp_c,
  input  logic [MV_W-1:0]       fb_mv,
  input  logic [MV_W-1:0]       ss_mv,
  output logic                  drv_off,
  output logic                  discharge,
  output logic                  restart_pulse
);
  localparam int SW = MV_W + 1;

  logic signed [SW-1:0] vbias_s;
  logic signed [SW-1:0] vin_s;
  logic bias_ok;
  logic vin_ok;
  logic hot;
  logic pwr_bad;
  logic short_now;

  assign vbias_s = $signed({1'b0, vbias_mv});
  assign vin_s   = $signed({1'b0, vin_sense_mv});

  hyst_flag #(.W(SW), .SET_AT(BIAS_ON), .CLR_AT(BIAS_OFF),
              .SET_INCL(1'b1), .CLR_INCL(1'b0), .RST_VAL(1'b0))
    u_bias (.clk(clk), .rst_n(rst_n), .val(vbias_s), .flag(bias_ok));

  hyst_flag #(.W(SW), .SET_AT(VIN_ON), .CLR_AT(VIN_OFF),
              .SET_INCL(1'b0), .CLR_INCL(1'b0), .RST_VAL(1'b0))
    u_vin (.clk(clk), .rst_n(rst_n), .val(vin_s), .flag(vin_ok));

  hyst_flag #(.W(T_W), .SET_AT(HOT_ON), .CLR_AT(HOT_OFF),
              .SET_INCL(1'b1), .CLR_INCL(1'b1), .RST_VAL(1'b1))
    u_temp (.clk(clk), .rst_n(rst_n), .val(temp_c), .flag(hot));

  assign pwr_bad = !bias_ok || !vin_ok || hot;

  short_detect #(.MV_W(MV_W), .VREF_MV(VREF_MV), .SHORT_MARGIN(SHORT_MARGIN))
    u_short (.fb_mv(fb_mv), .ss_mv(ss_mv), .short_now(short_now));

  hiccup_seq #(.IDLE_CYC(IDLE_CYC))
    u_seq (.clk(clk), .rst_n(rst_n), .pwr_bad(pwr_bad), .short_now(short_now),
           .drv_off(drv_off), .discharge(discharge), .restart_pulse(restart_pulse));
endmodule

// File: rtl/hiccup_supervisor_chk.sv
module hiccup_supervisor_chk #(
  parameter int MV_W     = 16,
  parameter int IDLE_CYC = 130000,
  parameter int BIAS_ON  = 4250
) (
  input logic            clk,
  input logic            rst_n,
  input logic [MV_W-1:0] vbias_mv,
  input logic            drv_off,
  input logic            discharge,
  input logic            restart_pulse,
  input logic            pwr_bad,
  input logic            short_now,
  input logic            bias_ok
);
  localparam int OC_W = $clog2(IDLE_CYC + 2) + 1;

  logic [OC_W-1:0] off_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                             off_cnt <= '0;
    else if (!drv_off)                      off_cnt <= '0;
    else if (off_cnt < OC_W'(IDLE_CYC + 1)) off_cnt <= off_cnt + 1'b1;
  end

  AST_BIAS_RISE_AT_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bias_ok) |-> (int'($past(vbias_mv)) >= BIAS_ON)); // R2
  AST_SHORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_off && short_now) |=> drv_off); // R5
  AST_LOCKOUT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_off && pwr_bad) |=> (drv_off && discharge)); // R6
  AST_IDLE_MIN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_off) |-> (off_cnt >= OC_W'(IDLE_CYC))); // R6
  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> !restart_pulse); // R8
  AST_RESTART_MARKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_off) |-> restart_pulse); // R8
  AST_NO_RESTART_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_off) |-> !$past(pwr_bad)); // R9
endmodule

bind hiccup_supervisor hiccup_supervisor_chk #(
  .MV_W(MV_W), .IDLE_CYC(IDLE_CYC), .BIAS_ON(BIAS_ON)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vbias_mv(vbias_mv), .drv_off(drv_off),
  .discharge(discharge), .restart_pulse(restart_pulse), .pwr_bad(pwr_bad),
  .short_now(short_now), .bias_ok(bias_ok)
);

// File: tb/hiccup_supervisor_tb.sv
`timescale 1ns/1ps
module hiccup_supervisor_tb;
  localparam int IDLE = 40;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [15:0]        vbias_mv = 16'd5000;
  logic [15:0]        vin_sense_mv = 16'd3000;
  logic signed [9:0]  temp_c = 10'sd25;
  logic [15:0]        fb_mv = 16'd800;
  logic [15:0]        ss_mv = 16'd800;
  logic               drv_off, discharge, restart_pulse;

  int    total = 0;
  int    bad = 0;
  int    cyc = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  hiccup_supervisor #(.IDLE_CYC(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .vbias_mv(vbias_mv), .vin_sense_mv(vin_sense_mv),
    .temp_c(temp_c), .fb_mv(fb_mv), .ss_mv(ss_mv),
    .drv_off(drv_off), .discharge(discharge), .restart_pulse(restart_pulse));

  // ---------------- reference model ----------------
  function automatic bit band(bit prev, bit up, bit down);
    if (up) return 1'b1;
    return down ? 1'b0 : prev;
  endfunction

  function automatic int ref_level(int ss);
    if (ss >= 800) return 800;
    return ss;
  endfunction

  int m_st = 1;  // 0 running, 1 idle, 2 held
  int m_cnt = 0;
  bit m_b = 0, m_v = 0, m_h = 1, m_rs = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 1; m_cnt = 0; m_b = 0; m_v = 0; m_h = 1; m_rs = 0;
    end else begin
      bit lock, sc;
      lock = !m_b || !m_v || m_h;
      sc   = (int'(fb_mv) + 250) < ref_level(int'(ss_mv));
      m_rs = 0;
      if (m_st == 0) begin
        if (lock || sc) begin m_st = 1; m_cnt = 0; end
      end else if (m_st == 1) begin
        if (m_cnt == IDLE - 1) begin
          if (lock) m_st = 2;
          else begin m_st = 0; m_rs = 1; end
        end else m_cnt++;
      end else begin
        if (!lock) begin m_st = 0; m_rs = 1; end
      end
      m_b = band(m_b, int'(vbias_mv) >= 4250, int'(vbias_mv) < 4050);
      m_v = band(m_v, int'(vin_sense_mv) > 2500, int'(vin_sense_mv) < 2200);
      m_h = band(m_h, int'(temp_c) >= 145, int'(temp_c) <= 135);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit eo;
      eo = (m_st != 0);
      total++;
      if (drv_off !== eo || discharge !== eo || restart_pulse !== m_rs) begin
        bad++;
        $display("FAIL %s model: drv_off=%0b discharge=%0b restart=%0b expected %0b %0b %0b",
                 cur_req, drv_off, discharge, restart_pulse, eo, eo, m_rs);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL R1 watchdog: cycles=%0d expected below 150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic go_good();
    vbias_mv = 16'd5000; vin_sense_mv = 16'd3000; temp_c = 10'sd25;
    fb_mv = 16'd800; ss_mv = 16'd800;
  endtask

  task automatic wait_run();
    int guard = 0;
    while (drv_off === 1'b1 && guard < 4 * IDLE + 20) begin step(1); guard++; end
    step(2);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd1234));
    go_good();
    step(3);
    cur_req = "R1";
    chk("R1", drv_off, 1'b1, "drv_off in reset");
    chk("R1", discharge, 1'b1, "discharge in reset");
    chk("R1", restart_pulse, 1'b0, "restart in reset");
    rst_n = 1'b1;
    step(1);
    chk("R1", drv_off, 1'b1, "drv_off after reset");

    cur_req = "R8";
    begin
      int pulses = 0;
      for (int i = 0; i < IDLE + 5; i++) begin step(1); if (restart_pulse) pulses++; end
      chk_int("R8", pulses, 1, "restart pulses at first start");
    end
    chk("R8", drv_off, 1'b0, "running after first start");

    // R6: single-cycle short, idle length
    cur_req = "R6";
    fb_mv = 16'd0; step(1); fb_mv = 16'd800;
    chk("R6", discharge, 1'b1, "discharge at fault");
    begin
      int n = 0;
      while (drv_off === 1'b1 && n < 4 * IDLE) begin n++; step(1); end
      chk_int("R6", n, IDLE, "idle cycles with drivers off");
    end
    step(2);

    // R2: bias hysteresis
    cur_req = "R2";
    vbias_mv = 16'd4100; step(4);
    chk("R2", drv_off, 1'b0, "bias 4100 inside band keeps running");
    vbias_mv = 16'd4049; step(1);
    chk("R2", drv_off, 1'b0, "one cycle after bias drop");
    step(1);
    chk("R2", drv_off, 1'b1, "bias 4049 stops");
    vbias_mv = 16'd4249; step(IDLE + 5);
    chk("R9", drv_off, 1'b1, "held while bias 4249");
    vbias_mv = 16'd4250; step(2);
    chk("R2", drv_off, 1'b0, "bias 4250 releases");
    chk("R8", restart_pulse, 1'b1, "pulse on release");
    step(1);
    chk("R8", restart_pulse, 1'b0, "pulse lasts one cycle");

    // R3: input sense
    cur_req = "R3";
    vin_sense_mv = 16'd2199; step(2);
    chk("R3", drv_off, 1'b1, "input 2199 stops");
    vin_sense_mv = 16'd2500; step(IDLE + 5);
    chk("R3", drv_off, 1'b1, "input 2500 does not release");
    vin_sense_mv = 16'd2501; step(2);
    chk("R3", drv_off, 1'b0, "input 2501 releases");
    go_good(); step(2);

    // R4 / R9: thermal
    cur_req = "R4";
    temp_c = 10'sd144; step(3);
    chk("R4", drv_off, 1'b0, "144 C keeps running");
    temp_c = 10'sd145; step(2);
    chk("R4", drv_off, 1'b1, "145 C stops");
    temp_c = 10'sd136; step(IDLE + 5);
    chk("R9", drv_off, 1'b1, "136 C still held after idle");
    temp_c = 10'sd135; step(1);
    chk("R9", drv_off, 1'b1, "one cycle after cooling");
    step(1);
    chk("R4", drv_off, 1'b0, "135 C releases");
    chk("R9", restart_pulse, 1'b1, "restart after thermal clear");
    go_good(); step(2);

    // R5: short threshold follows the soft-start level
    cur_req = "R5";
    fb_mv = 16'd550; step(2);
    chk("R5", drv_off, 1'b0, "fb 550 vs 800 not a short");
    ss_mv = 16'd300; fb_mv = 16'd50; step(2);
    chk("R5", drv_off, 1'b0, "fb 50 vs ss 300 not a short");
    fb_mv = 16'd49; step(1);
    chk("R5", drv_off, 1'b1, "fb 49 vs ss 300 is a short");
    fb_mv = 16'd800; ss_mv = 16'd800; wait_run();
    fb_mv = 16'd549; step(1);
    chk("R5", drv_off, 1'b1, "fb 549 vs 800 is a short");
    fb_mv = 16'd800; wait_run();

    // R7: persistent short retries
    cur_req = "R7";
    fb_mv = 16'd0; step(1);
    begin
      int pulses = 0;
      for (int i = 0; i < 3 * (IDLE + 1); i++) begin step(1); if (restart_pulse) pulses++; end
      chk_int("R7", pulses, 3, "retries during persistent short");
    end
    fb_mv = 16'd800; wait_run();

    // Random phase near every threshold
    cur_req = "R9";
    for (int blk = 0; blk < 600; blk++) begin
      int r;
      r = $urandom_range(0, 9);
      vbias_mv     = (r < 7) ? 16'd5000 : 16'($urandom_range(4000, 4300));
      r = $urandom_range(0, 9);
      vin_sense_mv = (r < 7) ? 16'd3000 : 16'($urandom_range(2150, 2550));
      r = $urandom_range(0, 9);
      temp_c       = (r < 7) ? 10'sd30 : 10'($urandom_range(130, 150));
      r = $urandom_range(0, 9);
      ss_mv        = 16'($urandom_range(0, 900));
      fb_mv        = (r < 8) ? 16'd790 : 16'($urandom_range(0, 800));
      step($urandom_range(1, 8));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule